// File: doc/BRIEF.md
# Edge/Level Interrupt Input Latch

This block conditions a bank of raw interrupt lines into per-processor pending flags. Each interrupt has a two-bit configuration field. One bit selects edge-sensitive or level-sensitive behaviour. The other bit is a spare model bit that is stored and read back. Lines are registered once. A pending flag is then set when a low-to-high change is seen on a line, subject to the trigger mode and the interrupt's enable.

Software-style register writes arrive on a plain strobe with an operation code, a byte index and a data byte. They cover configuration, enable set and clear, and pending set and clear. A separate end-of-interrupt strobe lets a level interrupt whose line is still high become pending again for the completing processor. The per-interrupt target masks come in from outside the block.

The lowest IDs are internal. Their trigger mode is always edge. The very lowest group, the software IDs, is also shielded from line input and from pending writes. Priority selection and address decode live elsewhere.

Top module: `irq_input_latch`

## Requirements
- R1: After reset no flag is pending and no interrupt is enabled. IDs below NUM_INTERNAL (32) read back config byte 0xAA and report edge mode. All other IDs read back 0x00 and report level mode.
- R2: Operation code 1 writes the config byte at index k, which covers IDs 4k to 4k+3. For ID 4k+i, bit 2i is the model bit and bit 2i+1 selects edge mode when set. `cfg_rd_data` returns the stored byte for `cfg_rd_idx` in the same cycle, and `irq_edge` follows the stored edge bits.
- R3: A config write to a byte covering IDs below 32 has 0xAA ORed into the data, so those IDs stay in edge mode.
- R4: In edge mode, a low-to-high change on a line sets pending for every processor whose target bit is set. The flag appears on the second rising clock edge after the change, whether or not the interrupt is enabled. A falling line leaves pending untouched.
- R5: In level mode, a rising line sets pending only if the interrupt is enabled. This includes an enable-set write that lands in the same cycle as the detected rise.
- R6: Operation code 2 (enable set) with data bit j at byte index k enables ID 8k+j. If that ID is in level mode and its registered line is high, the write also sets pending for its targets.
- R7: An end-of-interrupt for ID n from processor c sets pending for (n, c) on the next edge only when n is in level mode, enabled, its registered line is high, and target bit c is set.
- R8: Operation code 4 sets pending for the target processors of each selected ID. Operation code 5 clears pending for all processors. A set cause in the same cycle wins over a clear.
- R9: For IDs below NUM_SOFT (16), pending set and clear writes are ignored. An enable-set write to their bytes enables all eight IDs whatever the data. An enable-clear write to them changes nothing.
- R10: Lines of IDs below 16 never cause a pending flag.
- R11: Operation code 3 (enable clear) disables each selected ID of 16 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_line | input | NUM_IRQ | Raw interrupt lines, bit n is ID n |
| irq_target | input | NUM_IRQ*NUM_CPU | Target masks, bit n*NUM_CPU+c routes ID n to processor c |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 3 | Operation: 1 config, 2 enable set, 3 enable clear, 4 pending set, 5 pending clear |
| wr_idx | input | log2(NUM_IRQ/4) | Byte index of the write |
| wr_data | input | 8 | Write data byte |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_cpu | input | log2(NUM_CPU) | Completing processor |
| eoi_id | input | log2(NUM_IRQ) | Completed interrupt ID |
| cfg_rd_idx | input | log2(NUM_IRQ/4) | Config byte read index |
| cfg_rd_data | output | 8 | Config byte read data |
| irq_enabled | output | NUM_IRQ | Enable flags |
| irq_edge | output | NUM_IRQ | Edge-mode flags |
| irq_pending | output | NUM_IRQ*NUM_CPU | Pending flags, bit n*NUM_CPU+c |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a pending-clear write and a detected rising edge. The second is an enable-set write and the detection of a level rise. Both are provoked by changing the line and issuing the write exactly one clock later, so the write reaches the pending logic on the same edge as the detected rise. In both cases the flag must be set afterwards. The other functions are swept over every non-software ID with a mix of one-processor and two-processor target masks. The expected flag vectors are computed from the target pattern.

// File: rtl/irqlat_pkg.sv
package irqlat_pkg;
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_CFG     = 3'd1,
    OP_EN_SET  = 3'd2,
    OP_EN_CLR  = 3'd3,
    OP_PND_SET = 3'd4,
    OP_PND_CLR = 3'd5
  } reg_op_e;
endpackage

// File: rtl/irqlat_sync.sv
// Registers raw lines once, keeps the stored level and flags rises.
module irqlat_sync #(
  parameter int N    = 64,
  parameter int SOFT = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_in,
  output logic [N-1:0] line_q,
  output logic [N-1:0] rise
);
  // software IDs have no live line
  localparam logic [N-1:0] LIVE_MASK = {N{1'b1}} << SOFT;

  logic [N-1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      level_q <= '0;
    end else begin
      line_q  <= line_in & LIVE_MASK;
      level_q <= line_q;
    end
  end

  assign rise = line_q & ~level_q;
endmodule

// File: rtl/irqlat_cfg.sv
// Two-bit trigger configuration, packed four IDs per byte.
module irqlat_cfg #(
  parameter int N        = 64,
  parameter int INTERNAL = 32,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cfg,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [N-1:0]     edge_mode
);
  localparam int GROUPS = N / 4;

  logic [7:0] cfg_all [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam bit         FORCED = (4 * g < INTERNAL);
    localparam logic [7:0] RST    = FORCED ? 8'hAA : 8'h00;
    logic [7:0] byte_q;
    logic [7:0] wval;

    assign wval = FORCED ? (wr_data | 8'hAA) : wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  byte_q <= RST;
      else if (wr_cfg && wr_idx == IDX_W'(g))      byte_q <= wval;
    end

    assign cfg_all[g] = byte_q;
    for (genvar i = 0; i < 4; i++) begin : g_bit
      assign edge_mode[4*g+i] = byte_q[2*i+1];
    end
  end

  assign rd_data = cfg_all[rd_idx];
endmodule

// File: rtl/irqlat_pend.sv
// Enable flags and per-processor pending flags.
module irqlat_pend #(
  parameter int N     = 64,
  parameter int NC    = 2,
  parameter int SOFT  = 16,
  parameter int IDX_W = 4,
  parameter int CPU_W = 1,
  parameter int ID_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      line_q,
  input  logic [N-1:0]      rise,
  input  logic [N-1:0]      edge_mode,
  input  logic [N*NC-1:0]   target,
  input  logic              en_set_wr,
  input  logic              en_clr_wr,
  input  logic              ps_wr,
  input  logic              pc_wr,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  input  logic              eoi_valid,
  input  logic [CPU_W-1:0]  eoi_cpu,
  input  logic [ID_W-1:0]   eoi_id,
  output logic [N-1:0]      enabled,
  output logic [N*NC-1:0]   pending
);
  logic [N-1:0]    en_set_m, en_clr_m, ps_m, pc_m, en_next;
  logic [N*NC-1:0] pend_next;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      en_set_m[i] = en_set_wr && (wr_idx == IDX_W'(i / 8)) && ((i < SOFT) || wr_data[i % 8]);
      en_clr_m[i] = en_clr_wr && (wr_idx == IDX_W'(i / 8)) && (i >= SOFT) && wr_data[i % 8];
      ps_m[i]     = ps_wr     && (wr_idx == IDX_W'(i / 8)) && (i >= SOFT) && wr_data[i % 8];
      pc_m[i]     = pc_wr     && (wr_idx == IDX_W'(i / 8)) && (i >= SOFT) && wr_data[i % 8];
    end
    en_next = (enabled & ~en_clr_m) | en_set_m;
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < NC; c++) begin
        pend_next[i*NC+c] =
          (pending[i*NC+c] && !pc_m[i]) ||
          (target[i*NC+c] &&
            ((rise[i] && (edge_mode[i] || en_next[i])) ||
             (en_set_m[i] && !edge_mode[i] && line_q[i]) ||
             ps_m[i] ||
             (eoi_valid && eoi_id == ID_W'(i) && eoi_cpu == CPU_W'(c) &&
              !edge_mode[i] && enabled[i] && line_q[i])));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= '0;
      pending <= '0;
    end else begin
      enabled <= en_next;
      pending <= pend_next;
    end
  end
endmodule

// File: rtl/irq_input_latch.sv
module irq_input_latch #(
  parameter int NUM_IRQ      = 64,
  parameter int NUM_CPU      = 2,
  parameter int NUM_INTERNAL = 32,
  parameter int NUM_SOFT     = 16,
  parameter int IDX_W        = $clog2(NUM_IRQ / 4),
  parameter int ID_W         = $clog2(NUM_IRQ),
  parameter int CPU_W        = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IRQ-1:0]         irq_line,
  input  logic [NUM_IRQ*NUM_CPU-1:0] irq_target,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_op,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [7:0]                 wr_data,
  input  logic                       eoi_valid,
  input  logic [CPU_W-1:0]           eoi_cpu,
  input  logic [ID_W-1:0]            eoi_id,
  input  logic [IDX_W-1:0]           cfg_rd_idx,
  output logic [7:0]                 cfg_rd_data,
  output logic [NUM_IRQ-1:0]         irq_enabled,
  output logic [NUM_IRQ-1:0]         irq_edge,
  output logic [NUM_IRQ*NUM_CPU-1:0] irq_pending
);
  import irqlat_pkg::*;

  logic [NUM_IRQ-1:0] line_q, rise;
  logic wr_cfg, en_set_wr, en_clr_wr, ps_wr, pc_wr;

  assign wr_cfg    = wr_en && (wr_op == OP_CFG);
  assign en_set_wr = wr_en && (wr_op == OP_EN_SET);
  assign en_clr_wr = wr_en && (wr_op == OP_EN_CLR);
  assign ps_wr     = wr_en && (wr_op == OP_PND_SET);
  assign pc_wr     = wr_en && (wr_op == OP_PND_CLR);

  irqlat_sync #(.N(NUM_IRQ), .SOFT(NUM_SOFT)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(irq_line), .line_q(line_q), .rise(rise)
  );

  irqlat_cfg #(.N(NUM_IRQ), .INTERNAL(NUM_INTERNAL), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(cfg_rd_idx), .rd_data(cfg_rd_data), .edge_mode(irq_edge)
  );

  irqlat_pend #(.N(NUM_IRQ), .NC(NUM_CPU), .SOFT(NUM_SOFT), .IDX_W(IDX_W),
                .CPU_W(CPU_W), .ID_W(ID_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .line_q(line_q), .rise(rise), .edge_mode(irq_edge),
    .target(irq_target), .en_set_wr(en_set_wr), .en_clr_wr(en_clr_wr),
    .ps_wr(ps_wr), .pc_wr(pc_wr), .wr_idx(wr_idx), .wr_data(wr_data),
    .eoi_valid(eoi_valid), .eoi_cpu(eoi_cpu), .eoi_id(eoi_id),
    .enabled(irq_enabled), .pending(irq_pending)
  );
endmodule

// File: rtl/irq_input_latch_chk.sv
module irq_input_latch_chk #(
  parameter int NUM_IRQ      = 64,
  parameter int NUM_CPU      = 2,
  parameter int NUM_INTERNAL = 32,
  parameter int NUM_SOFT     = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_IRQ*NUM_CPU-1:0] irq_target,
  input logic [NUM_IRQ-1:0]         irq_enabled,
  input logic [NUM_IRQ-1:0]         irq_edge,
  input logic [NUM_IRQ*NUM_CPU-1:0] irq_pending
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_pending == '0 && irq_enabled == '0));

  // R3
  internal_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_edge[NUM_INTERNAL-1:0] == {NUM_INTERNAL{1'b1}});

  // R10
  soft_pend_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending[NUM_SOFT*NUM_CPU-1:0] == '0);

  // R9
  soft_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_enabled[NUM_SOFT-1:0]) & ~irq_enabled[NUM_SOFT-1:0]) == '0);

  // R8
  tgt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending & ~$past(irq_pending) & ~$past(irq_target)) == '0);
endmodule

bind irq_input_latch irq_input_latch_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .NUM_INTERNAL(NUM_INTERNAL), .NUM_SOFT(NUM_SOFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_target(irq_target), .irq_enabled(irq_enabled),
  .irq_edge(irq_edge), .irq_pending(irq_pending)
);

// File: tb/irq_input_latch_tb.sv
module irq_input_latch_tb;
  import irqlat_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 64;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0]    irq_line = '0;
  logic [NI*NC-1:0] irq_target = '0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_op = '0;
  logic [3:0]       wr_idx = '0;
  logic [7:0]       wr_data = '0;
  logic             eoi_valid = 1'b0;
  logic [0:0]       eoi_cpu = '0;
  logic [5:0]       eoi_id = '0;
  logic [3:0]       cfg_rd_idx = '0;
  logic [7:0]       cfg_rd_data;
  logic [NI-1:0]    irq_enabled, irq_edge;
  logic [NI*NC-1:0] irq_pending;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_input_latch u_dut (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .irq_target(irq_target),
    .wr_en(wr_en), .wr_op(wr_op), .wr_idx(wr_idx), .wr_data(wr_data),
    .eoi_valid(eoi_valid), .eoi_cpu(eoi_cpu), .eoi_id(eoi_id),
    .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
    .irq_enabled(irq_enabled), .irq_edge(irq_edge), .irq_pending(irq_pending)
  );

  function automatic logic [1:0] tgt(int id);
    return 2'((id % 3) + 1);
  endfunction

  function automatic logic [127:0] tvec(int id);
    logic [127:0] r = '0;
    r[id*2 +: 2] = tgt(id);
    return r;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] op, int idx, logic [7:0] d);
    wr_en = 1'b1; wr_op = op; wr_idx = 4'(idx); wr_data = d;
    tick();
    wr_en = 1'b0; wr_op = OP_IDLE;
  endtask

  task automatic eoi(int cpu, int id);
    eoi_valid = 1'b1; eoi_cpu = 1'(cpu); eoi_id = 6'(id);
    tick();
    eoi_valid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [127:0] e;
    logic [7:0] pats [5] = '{8'h00, 8'h55, 8'hFF, 8'h3C, 8'hC3};
    for (int id = 0; id < NI; id++) begin
      for (int c = 0; c < NC; c++) irq_target[id*NC+c] = tgt(id)[c];
    end
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 pending", irq_pending, '0);
    chk("R1 enabled", irq_enabled, '0);
    chk("R1 edge", irq_edge, {32'h0, 32'hFFFF_FFFF});
    for (int g = 0; g < 16; g++) begin
      cfg_rd_idx = 4'(g); #1;
      chk("R1 cfg", cfg_rd_data, (g < 8) ? 8'hAA : 8'h00);
    end

    // R2 / R3 config packing sweep
    for (int g = 0; g < 16; g++) begin
      for (int p = 0; p < 5; p++) begin
        logic [7:0] d;
        logic [7:0] ex;
        d = pats[p];
        ex = (g < 8) ? (d | 8'hAA) : d;
        wr(OP_CFG, g, d);
        cfg_rd_idx = 4'(g); #1;
        chk((g < 8) ? "R3 cfg force" : "R2 cfg readback", cfg_rd_data, ex);
        chk("R2 edge bits", irq_edge[4*g +: 4], {ex[7], ex[5], ex[3], ex[1]});
      end
    end

    // R4 edge mode on all non-software IDs, disabled
    for (int g = 8; g < 16; g++) wr(OP_CFG, g, 8'hAA);
    for (int id = 16; id < NI; id++) begin
      irq_line[id] = 1'b1;
      tick();
      chk("R4 one edge latency", irq_pending, '0);
      tick();
      chk("R4 edge pend", irq_pending, tvec(id));
      irq_line[id] = 1'b0;
      tick(); tick();
      chk("R4 fall keeps", irq_pending, tvec(id));
      wr(OP_PND_CLR, id / 8, 8'(1 << (id % 8)));
      chk("R8 clear", irq_pending, '0);
    end

    // R10 software lines
    irq_line[15:0] = '1;
    tick(); tick();
    chk("R10 soft lines", irq_pending, '0);
    irq_line[15:0] = '0;
    tick(); tick();

    // R5 R6 R7 R11 level mode
    for (int g = 8; g < 16; g++) wr(OP_CFG, g, 8'h00);
    for (int id = 32; id < NI; id++) begin
      irq_line[id] = 1'b1;
      tick(); tick();
      chk("R5 disabled level", irq_pending, '0);
      wr(OP_EN_SET, id / 8, 8'(1 << (id % 8)));
      chk("R6 enabled", irq_enabled[id], 1'b1);
      chk("R6 enable pends", irq_pending, tvec(id));
      irq_line[id] = 1'b0;
      tick(); tick();
      wr(OP_PND_CLR, id / 8, 8'(1 << (id % 8)));
      irq_line[id] = 1'b1;
      tick(); tick();
      chk("R5 enabled rise", irq_pending, tvec(id));
      wr(OP_PND_CLR, id / 8, 8'(1 << (id % 8)));
      e = '0;
      eoi(0, id);
      e[id*2] = tgt(id)[0];
      chk("R7 eoi cpu0", irq_pending, e);
      eoi(1, id);
      e[id*2+1] = tgt(id)[1];
      chk("R7 eoi cpu1", irq_pending, e);
      irq_line[id] = 1'b0;
      tick(); tick();
      wr(OP_PND_CLR, id / 8, 8'(1 << (id % 8)));
      eoi(0, id);
      eoi(1, id);
      chk("R7 eoi line low", irq_pending, '0);
      wr(OP_EN_CLR, id / 8, 8'(1 << (id % 8)));
      chk("R11 enable clear", irq_enabled[id], 1'b0);
    end

    // R7 edge-mode ID not re-pended at completion
    wr(OP_EN_SET, 2, 8'h01);
    irq_line[16] = 1'b1;
    tick(); tick();
    chk("R4 edge id16", irq_pending, tvec(16));
    wr(OP_PND_CLR, 2, 8'h01);
    eoi(0, 16); eoi(1, 16);
    chk("R7 edge eoi", irq_pending, '0);
    irq_line[16] = 1'b0;
    tick(); tick();

    // R8 pending set/clear patterns
    for (int b = 2; b < 8; b++) begin
      logic [7:0] dp [3] = '{8'h5A, 8'hFF, 8'h81};
      for (int p = 0; p < 3; p++) begin
        e = '0;
        for (int i = 0; i < 8; i++) if (dp[p][i]) e = e | tvec(8*b + i);
        wr(OP_PND_SET, b, dp[p]);
        chk("R8 pend set", irq_pending, e);
        wr(OP_PND_CLR, b, dp[p]);
        chk("R8 pend clr", irq_pending, '0);
      end
    end

    // R8 same cycle: clear against detected rise, set wins
    wr(OP_EN_SET, 5, 8'h01);
    wr(OP_PND_SET, 5, 8'h01);
    irq_line[40] = 1'b1;
    tick();
    wr(OP_PND_CLR, 5, 8'h01);
    chk("R8 set beats clear", irq_pending, tvec(40));
    irq_line[40] = 1'b0;
    tick(); tick();
    wr(OP_PND_CLR, 5, 8'h01);
    chk("R8 cleanup", irq_pending, '0);

    // R5 same cycle: enable write meets the rise
    irq_line[41] = 1'b1;
    tick();
    wr(OP_EN_SET, 5, 8'h02);
    chk("R5 enable with rise", irq_pending, tvec(41));
    irq_line[41] = 1'b0;
    tick(); tick();
    wr(OP_PND_CLR, 5, 8'h02);

    // R9 software IDs
    wr(OP_PND_SET, 0, 8'hFF);
    wr(OP_PND_SET, 1, 8'hFF);
    chk("R9 soft pend set ignored", irq_pending, '0);
    wr(OP_EN_SET, 0, 8'h00);
    chk("R9 soft enable forced", irq_enabled[7:0], 8'hFF);
    wr(OP_EN_SET, 1, 8'h10);
    chk("R9 soft enable forced hi", irq_enabled[15:8], 8'hFF);
    wr(OP_EN_CLR, 0, 8'hFF);
    wr(OP_EN_CLR, 1, 8'hFF);
    chk("R9 soft enable clear ignored", irq_enabled[15:0], 16'hFFFF);

    summary();
    $finish;
  end
endmodule